// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block produces the timing strobes for an asynchronous serial port. It turns the peripheral clock into a regular sample strobe and a slower bit strobe. The division chain has three stages. First, a prescaler set by a 2-bit clock-select code. Second, an 8-bit divisor register plus one. Third, an oversampling stage whose length is 64, 32 or 16 clocks per bit, chosen by two mode flags. The transmit and receive paths use the strobes as clock enables.

The resulting bit period is base × factor × (N+1) clocks, where N is the divisor register. The factor is ½, 2, 8 or 32 for clock-select codes 0 to 3. The ½ factor would leave half-clock counts, so the chain folds one factor of two from the base into the prescaler. The prescaler therefore divides by 4^k and the oversampling stage counts base/2 sample strobes per bit, and every count stays an integer.

The divisor register shares one access port with a modulation-duty register. A select bit in the mode register chooses which of the two that port reaches. The divisor is locked against writes while either direction is enabled. The modulation-duty value is only stored and read back. Writing the mode register, an accepted divisor write, or a change of the clock-select code restarts the count.

Top module: `baud_prescaler`

## Requirements
- R1: After reset both shared registers hold 0xFF, the mode bits are 0 (so the shared port reaches the divisor), and both strobes are low.
- R2: While running, `sample_tick` is a one-cycle-wide high pulse repeating every 4^k × (N+1) clocks, where k is `clk_sel` and N is the divisor register.
- R3: `bit_tick` pulses together with every S-th `sample_tick`. S is 32 with mode bits 7 and 0 both clear, 16 with exactly one of them set, and 8 with both set. The bit period is therefore (2S) × 2^(2k−1) × (N+1) clocks.
- R4: While `tx_en` and `rx_en` are both low the counters are held at zero and neither strobe pulses. The first `sample_tick` appears in the cycle after the 4^k × (N+1)-th clock edge that has an enable set.
- R5: A write to the divisor through the shared port is ignored while `tx_en` or `rx_en` is high. The old value stays readable.
- R6: Bit 4 of the mode register selects the target of the shared port: 0 reaches the divisor and 1 reaches the modulation-duty register, for both `shared_rdata` and writes. Modulation-duty writes are accepted whatever the enables are.
- R7: A mode register write, an accepted divisor write, or a change of `clk_sel` clears all counters at that edge. Counting then starts over under the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 2 | Prescaler code k (divide by 4^k) |
| tx_en | input | 1 | Transmit direction enabled |
| rx_en | input | 1 | Receive direction enabled |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode data: bit 0 eight-times base, bit 4 port select, bit 7 double speed |
| shared_wr | input | 1 | Write strobe for the shared divisor / modulation-duty port |
| shared_wdata | input | 8 | Data for the shared port |
| shared_rdata | output | 8 | Read value of the register the port currently selects |
| sample_tick | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit-period strobe, one cycle wide |

## Verification
The bench builds the block with its default parameters: a 2-bit clock select, an 8-bit divisor and a 64-clock base. It sweeps all four prescaler codes with small divisors, so the longest strobe period stays at a few hundred clocks. It covers all three oversampling lengths with divisor 0 and code 0, where the sample strobe fires on every enabled clock. This brings the bit-strobe wrap at 8, 16 and 32 within a short run. It also reaches locked divisor writes, port-select switching and restarts in the middle of a count.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int REG_W = 8;

    localparam int MODE_BASE8_BIT = 0;
    localparam int MODE_SEL_BIT   = 4;
    localparam int MODE_DBL_BIT   = 7;

    typedef struct packed {
        logic [REG_W-1:0] divisor;
        logic [REG_W-1:0] duty;
        logic             sel_duty;
        logic             base8;
        logic             dbl;
    } rate_cfg_t;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             mode_wr_i,
    input  logic [REG_W-1:0] mode_wdata_i,
    input  logic             shared_wr_i,
    input  logic [REG_W-1:0] shared_wdata_i,
    output rate_cfg_t        cfg_o,
    output logic             div_taken_o,
    output logic [REG_W-1:0] rdata_o
);
    rate_cfg_t cfg_d, cfg_q;
    logic      div_taken_d;

    always_comb begin
        cfg_d       = cfg_q;
        div_taken_d = 1'b0;
        if (shared_wr_i) begin
            if (cfg_q.sel_duty) begin
                cfg_d.duty = shared_wdata_i;
            end else if (!run_i) begin
                cfg_d.divisor = shared_wdata_i;
                div_taken_d   = 1'b1;
            end
        end
        if (mode_wr_i) begin
            cfg_d.base8    = mode_wdata_i[MODE_BASE8_BIT];
            cfg_d.sel_duty = mode_wdata_i[MODE_SEL_BIT];
            cfg_d.dbl      = mode_wdata_i[MODE_DBL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.divisor  <= '1;
            cfg_q.duty     <= '1;
            cfg_q.sel_duty <= 1'b0;
            cfg_q.base8    <= 1'b0;
            cfg_q.dbl      <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o       = cfg_q;
    assign div_taken_o = div_taken_d;
    assign rdata_o     = cfg_q.sel_duty ? cfg_q.duty : cfg_q.divisor;

    // R5: divisor frozen while a direction is enabled
    a_r5_divisor_locked: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(cfg_q.divisor));

    // R6: with the divisor selected, the duty value cannot move
    a_r6_duty_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_wr_i && !cfg_q.sel_duty) |=> $stable(cfg_q.duty));
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         at_top;

    assign at_top = (cnt_q == limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = at_top ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wrap_o = step_i && !clr_i && at_top;

    // R2: a stage never counts past its limit
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit_i);
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int CKS_W     = 2,
    parameter int BASE_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CKS_W-1:0] clk_sel,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             mode_wr,
    input  logic [REG_W-1:0] mode_wdata,
    input  logic             shared_wr,
    input  logic [REG_W-1:0] shared_wdata,
    output logic [REG_W-1:0] shared_rdata,
    output logic             sample_tick,
    output logic             bit_tick
);
    localparam int PRE_W = 2 * ((1 << CKS_W) - 1);
    localparam int BIT_W = BASE_LOG2 - 1;

    typedef struct packed {
        logic [CKS_W-1:0] ks;
        logic             sample;
        logic             bitp;
    } top_state_t;

    top_state_t st_d, st_q;
    rate_cfg_t  cfg;
    logic       div_taken;
    logic       run, restart, clr;
    logic       pre_wrap, div_wrap, bit_wrap;
    logic [PRE_W-1:0] pre_lim;
    logic [BIT_W-1:0] bit_lim;
    logic [PRE_W:0]   pre_span;
    logic [BIT_W:0]   bit_span;

    assign run = tx_en || rx_en;

    baud_cfg_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run),
        .mode_wr_i      (mode_wr),
        .mode_wdata_i   (mode_wdata),
        .shared_wr_i    (shared_wr),
        .shared_wdata_i (shared_wdata),
        .cfg_o          (cfg),
        .div_taken_o    (div_taken),
        .rdata_o        (shared_rdata)
    );

    always_comb begin
        pre_span = {{PRE_W{1'b0}}, 1'b1} << (2 * int'(st_q.ks));
        pre_lim  = PRE_W'(pre_span - 1'b1);
        bit_span = {{BIT_W{1'b0}}, 1'b1} << (BIT_W - int'(cfg.dbl) - int'(cfg.base8));
        bit_lim  = BIT_W'(bit_span - 1'b1);
    end

    assign restart = mode_wr || div_taken || (clk_sel != st_q.ks);
    assign clr     = restart || !run;

    baud_div_counter #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(run),
        .limit_i(pre_lim), .wrap_o(pre_wrap)
    );

    baud_div_counter #(.W(REG_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(pre_wrap),
        .limit_i(cfg.divisor), .wrap_o(div_wrap)
    );

    baud_div_counter #(.W(BIT_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(div_wrap),
        .limit_i(bit_lim), .wrap_o(bit_wrap)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ks     = clk_sel;
        st_d.sample = div_wrap;
        st_d.bitp   = bit_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_tick = st_q.sample;
    assign bit_tick    = st_q.bitp;

    // R3: a bit strobe always lands on a sample strobe
    a_r3_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    // R4: idle directions give no strobe in the next cycle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en || rx_en) |=> !sample_tick && !bit_tick);

    // R7: a mode write restarts the chain, so no strobe follows it
    a_r7_mode_restart: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !sample_tick && !bit_tick);
endmodule

// File: tb/tb_baud_prescaler.sv
module tb_baud_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic       mode_wr = 1'b0, shared_wr = 1'b0;
    logic [7:0] mode_wdata = 8'h00, shared_wdata = 8'h00;
    logic [7:0] shared_rdata;
    logic       sample_tick, bit_tick;

    always #4 clk = ~clk;

    baud_prescaler dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tx_en(tx_en), .rx_en(rx_en),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .shared_wr(shared_wr),
        .shared_wdata(shared_wdata), .shared_rdata(shared_rdata),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    int    errors = 0, checks = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference
    int       m_cnt;
    int       m_ks;
    bit [7:0] m_div, m_duty;
    bit       m_sel, m_b8, m_dbl, m_s, m_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ks = 0; m_div = 8'hFF; m_duty = 8'hFF;
            m_sel = 0; m_b8 = 0; m_dbl = 0; m_s = 0; m_b = 0;
        end else begin
            bit run, rs;
            int per, slen;
            run = tx_en | rx_en;
            rs  = mode_wr || (shared_wr && !m_sel && !run) || (int'(clk_sel) != m_ks);
            if (shared_wr) begin
                if (m_sel) m_duty = shared_wdata;
                else if (!run) m_div = shared_wdata;
            end
            if (mode_wr) begin
                m_b8 = mode_wdata[0]; m_sel = mode_wdata[4]; m_dbl = mode_wdata[7];
            end
            m_ks = int'(clk_sel);
            if (!run || rs) begin
                m_cnt = 0; m_s = 0; m_b = 0;
            end else begin
                m_cnt++;
                per  = (1 << (2 * m_ks)) * (int'(m_div) + 1);
                slen = 32 >> (int'(m_dbl) + int'(m_b8));
                m_s  = (m_cnt % per) == 0;
                m_b  = (m_cnt % (per * slen)) == 0;
            end
        end
    end

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("sample_tick", int'(sample_tick), int'(m_s));
            chk("bit_tick", int'(bit_tick), int'(m_b));
            chk("shared_rdata", int'(shared_rdata), int'(m_sel ? m_duty : m_div));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [7:0] v);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic wr_shared(input logic [7:0] v);
        @(negedge clk); shared_wr = 1'b1; shared_wdata = v;
        @(negedge clk); shared_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("reset sample_tick", int'(sample_tick), 0);
        chk("reset bit_tick", int'(bit_tick), 0);
        chk("reset shared_rdata", int'(shared_rdata), 8'hFF);
        rst_n = 1'b1;
        idle(4);

        // R6: port select and duty register
        cur_req = "R6";
        wr_mode(8'h10);
        wr_shared(8'h5A);
        idle(2);
        wr_mode(8'h00);
        idle(2);
        rx_en = 1'b1;
        wr_mode(8'h10);
        wr_shared(8'hC3);
        idle(2);
        rx_en = 1'b0;
        wr_mode(8'h00);

        // R2: prescaler codes with small divisors
        cur_req = "R2";
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); clk_sel = k[1:0];
            wr_shared(8'(k == 3 ? 0 : 2));
            rx_en = 1'b1;
            idle(k == 3 ? 260 : 200);
            rx_en = 1'b0;
            idle(3);
        end

        // R3: oversampling lengths with the fastest sample strobe
        cur_req = "R3";
        @(negedge clk); clk_sel = 2'd0;
        wr_shared(8'h00);
        for (int m = 0; m < 4; m++) begin
            wr_mode({m[1], 6'b0, m[0]});
            tx_en = 1'b1;
            idle(80);
            tx_en = 1'b0;
            idle(2);
        end
        wr_mode(8'h00);

        // R5: divisor locked while enabled
        cur_req = "R5";
        wr_shared(8'h01);
        tx_en = 1'b1;
        idle(5);
        wr_shared(8'h07);
        idle(30);
        rx_en = 1'b1; tx_en = 1'b0;
        wr_shared(8'h09);
        idle(10);
        rx_en = 1'b0;
        idle(2);

        // R4: start-up latency and idle hold
        cur_req = "R4";
        @(negedge clk); clk_sel = 2'd1;
        tx_en = 1'b1;
        idle(13);
        tx_en = 1'b0;
        idle(5);
        tx_en = 1'b1;
        idle(20);

        // R7: restarts mid-count
        cur_req = "R7";
        idle(3);
        wr_mode(8'h80);
        idle(11);
        @(negedge clk); clk_sel = 2'd2;
        idle(40);
        @(negedge clk); clk_sel = 2'd0;
        idle(40);
        tx_en = 1'b0;
        idle(2);
        wr_shared(8'h03);
        tx_en = 1'b1;
        idle(50);
        tx_en = 1'b0;
        idle(3);

        finish_run();
    end
endmodule